// File: doc/BRIEF.md
# DMA Window Address Translator

The block converts a bus address presented by a DMA master into a physical memory address. Four programmable windows are held in registers. Each window has a base register, a size mask register and a translated-base register, all 64 bits wide. A window claims an address when the address's bits 30:20 agree with the window base in every position that the size mask leaves clear. The physical address is then formed from the translated base, with the low bits inside the window carried straight over from the bus address.

Software programs the twelve registers through a simple 64-bit register port. Register reads are combinational, and writes take effect on the clock edge. A request port accepts one bus address per cycle. One cycle later it returns a response strobe together with a hit flag, an error flag and the translated address.

Windows are searched in a fixed priority order, and windows that are not enabled are passed over. A window set to scatter-gather mode is not translated. When such a window is the one selected, the block reports an error instead.

Top module: `dma_xlat`

## Requirements
- R1: After reset all twelve window registers read zero, and rsp_valid_o, rsp_hit_o, rsp_err_o and rsp_addr_o are zero.
- R2: Registers sit at byte offsets 0x00/0x08/0x10/0x18 (window base 0..3), 0x20/0x28/0x30/0x38 (size mask 0..3) and 0x40/0x48/0x50/0x58 (translated base 0..3). reg_rdata_o shows the addressed register in the same cycle. A write with reg_we_i high stores reg_wdata_i at the next rising edge.
- R3: An offset whose low three bits are not zero, or one at 0x60 and above, reads zero. A write to such an offset changes no register.
- R4: A window matches when bus-address bits 30:20 equal window-base bits 30:20 in every position where the size mask bit is 0. All other address bits take no part in the compare.
- R5: Bit 0 of a window base is its enable. A matching window whose enable is 0 is skipped, and the search goes on to the next window.
- R6: Windows are searched from index 0 to index 3, and the first enabled matching window decides the response.
- R7: Bit 1 of a window base selects scatter-gather mode. If the deciding window has this bit set, the response has rsp_err_o=1, rsp_hit_o=0 and rsp_addr_o=0.
- R8: On a direct-mapped hit, rsp_hit_o=1 and rsp_err_o=0. The pass-through mask is (size mask AND bits 30:20) OR 0xFFFFF. rsp_addr_o is (translated base AND NOT pass) OR (bus address AND pass).
- R9: When no enabled window matches, rsp_hit_o=0, rsp_err_o=0 and rsp_addr_o=0.
- R10: rsp_valid_o is high exactly in the cycle after a cycle with req_valid_i high. The hit, error and address outputs are registered together with it, and they hold their values while no request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Register read data (combinational) |
| req_valid_i | input | 1 | Translation request strobe |
| req_addr_i | input | 64 | Bus address to translate |
| rsp_valid_o | output | 1 | Response strobe, one cycle after request |
| rsp_hit_o | output | 1 | Direct-mapped translation found |
| rsp_err_o | output | 1 | Deciding window is in scatter-gather mode |
| rsp_addr_o | output | 64 | Translated physical address |

## Verification
Register reads are combinational, so the bench sets the offset at a falling edge and samples a moment later. A write is driven for one full cycle and is read back only after the rising edge that stores it. A translation request is driven from one falling edge to the next. Its response is registered at the single rising edge in between, so the bench compares the strobe, flags and address at that next falling edge. It then checks several idle cycles later that the strobe has dropped while the flags and address have held.

// File: rtl/dma_xlat_pkg.sv
package dma_xlat_pkg;
  localparam int unsigned NUM_WIN = 4;
  localparam int unsigned DATA_W  = 64;
  localparam int unsigned REG_AW  = 8;
  localparam int unsigned CMP_LO  = 20;
  localparam int unsigned CMP_HI  = 30;
  localparam int unsigned EN_BIT  = 0;
  localparam int unsigned SG_BIT  = 1;
endpackage

// File: rtl/dma_win_regs.sv
module dma_win_regs
  import dma_xlat_pkg::*;
#(
  parameter int unsigned N_WIN = NUM_WIN,
  parameter int unsigned DW    = DATA_W,
  parameter int unsigned AW    = REG_AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] base_o  [N_WIN],
  output logic [DW-1:0] mask_o  [N_WIN],
  output logic [DW-1:0] tbase_o [N_WIN]
);
  localparam int unsigned N_REGS  = 3 * N_WIN;
  localparam int unsigned IDX_W   = $clog2(N_REGS);
  localparam int unsigned OFF_LSB = $clog2(DW / 8);
  localparam int unsigned SLOT_W  = AW - OFF_LSB;

  logic [DW-1:0]    regs_q [N_REGS];
  logic [SLOT_W-1:0] slot;
  logic [IDX_W-1:0]  idx;
  logic              mapped;

  assign slot   = addr_i[AW-1:OFF_LSB];
  assign idx    = slot[IDX_W-1:0];
  assign mapped = (addr_i[OFF_LSB-1:0] == '0) && (slot < SLOT_W'(N_REGS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < N_REGS; r++) regs_q[r] <= '0;
    end else if (we_i && mapped) begin
      for (int r = 0; r < N_REGS; r++)
        if (idx == IDX_W'(r)) regs_q[r] <= wdata_i;
    end
  end

  assign rdata_o = mapped ? regs_q[idx] : '0;

  for (genvar w = 0; w < N_WIN; w++) begin : g_out
    assign base_o[w]  = regs_q[w];
    assign mask_o[w]  = regs_q[N_WIN + w];
    assign tbase_o[w] = regs_q[2 * N_WIN + w];
  end

  // R2
  wr_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && mapped) |=> (regs_q[$past(idx)] == $past(wdata_i)));

  // R3
  wr_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !mapped) |=> $stable(regs_q[0]) && $stable(regs_q[N_REGS-1]));
endmodule

// File: rtl/dma_win_match.sv
module dma_win_match
  import dma_xlat_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned LO = CMP_LO,
  parameter int unsigned HI = CMP_HI
) (
  input  logic [DW-1:0] base_i,
  input  logic [DW-1:0] mask_i,
  input  logic [DW-1:0] tbase_i,
  input  logic [DW-1:0] addr_i,
  output logic          hit_o,
  output logic          sg_o,
  output logic [DW-1:0] xlat_o
);
  localparam logic [DW-1:0] FIELD =
    {{(DW-HI-1){1'b0}}, {(HI-LO+1){1'b1}}, {LO{1'b0}}};
  localparam logic [DW-1:0] LOW = {{(DW-LO){1'b0}}, {LO{1'b1}}};

  logic [DW-1:0] cmp_m;
  logic [DW-1:0] pass_m;
  logic          match;

  assign cmp_m  = ~mask_i & FIELD;
  assign match  = ((addr_i ^ base_i) & cmp_m) == '0;
  assign hit_o  = match & base_i[EN_BIT];
  assign sg_o   = base_i[SG_BIT];
  assign pass_m = (mask_i & FIELD) | LOW;
  assign xlat_o = (tbase_i & ~pass_m) | (addr_i & pass_m);
endmodule

// File: rtl/dma_win_pick.sv
module dma_win_pick
  import dma_xlat_pkg::*;
#(
  parameter int unsigned N_WIN = NUM_WIN,
  parameter int unsigned DW    = DATA_W
) (
  input  logic [N_WIN-1:0] hit_i,
  input  logic [N_WIN-1:0] sg_i,
  input  logic [DW-1:0]    xlat_i [N_WIN],
  output logic             hit_o,
  output logic             err_o,
  output logic [DW-1:0]    addr_o
);
  logic found;

  always_comb begin
    found  = 1'b0;
    hit_o  = 1'b0;
    err_o  = 1'b0;
    addr_o = '0;
    for (int w = 0; w < N_WIN; w++) begin
      if (!found && hit_i[w]) begin
        found = 1'b1;
        if (sg_i[w]) err_o = 1'b1;
        else begin
          hit_o  = 1'b1;
          addr_o = xlat_i[w];
        end
      end
    end
  end
endmodule

// File: rtl/dma_xlat.sv
module dma_xlat
  import dma_xlat_pkg::*;
#(
  parameter int unsigned N_WIN = NUM_WIN,
  parameter int unsigned DW    = DATA_W,
  parameter int unsigned AW    = REG_AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          req_valid_i,
  input  logic [DW-1:0] req_addr_i,
  output logic          rsp_valid_o,
  output logic          rsp_hit_o,
  output logic          rsp_err_o,
  output logic [DW-1:0] rsp_addr_o
);
  logic [DW-1:0]    win_base  [N_WIN];
  logic [DW-1:0]    win_mask  [N_WIN];
  logic [DW-1:0]    win_tbase [N_WIN];
  logic [DW-1:0]    win_xlat  [N_WIN];
  logic [N_WIN-1:0] win_hit;
  logic [N_WIN-1:0] win_sg;
  logic             pick_hit;
  logic             pick_err;
  logic [DW-1:0]    pick_addr;

  dma_win_regs #(.N_WIN(N_WIN), .DW(DW), .AW(AW)) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .base_o  (win_base),
    .mask_o  (win_mask),
    .tbase_o (win_tbase)
  );

  for (genvar w = 0; w < N_WIN; w++) begin : g_win
    dma_win_match #(.DW(DW)) i_match (
      .base_i  (win_base[w]),
      .mask_i  (win_mask[w]),
      .tbase_i (win_tbase[w]),
      .addr_i  (req_addr_i),
      .hit_o   (win_hit[w]),
      .sg_o    (win_sg[w]),
      .xlat_o  (win_xlat[w])
    );
  end

  dma_win_pick #(.N_WIN(N_WIN), .DW(DW)) i_pick (
    .hit_i  (win_hit),
    .sg_i   (win_sg),
    .xlat_i (win_xlat),
    .hit_o  (pick_hit),
    .err_o  (pick_err),
    .addr_o (pick_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_addr_o  <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        rsp_hit_o  <= pick_hit;
        rsp_err_o  <= pick_err;
        rsp_addr_o <= pick_addr;
      end
    end
  end

  // R10
  rsp_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  // R10
  rsp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!rsp_valid_o && $stable(rsp_addr_o) && $stable(rsp_hit_o)
                      && $stable(rsp_err_o)));

  // R7
  err_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> (!rsp_hit_o && rsp_addr_o == '0));

  // R9
  miss_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_hit_o |-> (rsp_addr_o == '0));

  // R8
  low_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && pick_hit) |=> (rsp_addr_o[CMP_LO-1:0] == $past(req_addr_i[CMP_LO-1:0])));
endmodule

// File: tb/test_dma_xlat.sv
module test_dma_xlat;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] FIELD = 64'h0000_0000_7FF0_0000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [7:0]  reg_addr_i = '0;
  logic [63:0] reg_wdata_i = '0;
  logic [63:0] reg_rdata_o;
  logic        req_valid_i = 1'b0;
  logic [63:0] req_addr_i = '0;
  logic        rsp_valid_o, rsp_hit_o, rsp_err_o;
  logic [63:0] rsp_addr_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [63:0] sb [4];
  logic [63:0] sm [4];
  logic [63:0] st [4];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dma_xlat i_dma_xlat (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .req_valid_i, .req_addr_i, .rsp_valid_o, .rsp_hit_o, .rsp_err_o, .rsp_addr_o
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [63:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [63:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic set_win(int i, logic [63:0] b, logic [63:0] m, logic [63:0] t);
    wr(8'(8*i), b);       sb[i] = b;
    wr(8'(8*(4+i)), m);   sm[i] = m;
    wr(8'(8*(8+i)), t);   st[i] = t;
  endtask

  task automatic clear_all();
    for (int i = 0; i < 4; i++) set_win(i, '0, '0, '0);
  endtask

  function automatic void model(logic [63:0] a, output logic h, output logic e,
                                output logic [63:0] r);
    logic [63:0] cm, pm;
    h = 0; e = 0; r = '0;
    for (int i = 0; i < 4; i++) begin
      cm = ~sm[i] & FIELD;
      if (((a & cm) == (sb[i] & cm)) && sb[i][0]) begin
        if (sb[i][1]) e = 1;
        else begin
          pm = (sm[i] & FIELD) | 64'hF_FFFF;
          h = 1;
          r = (st[i] & ~pm) | (a & pm);
        end
        return;
      end
    end
  endfunction

  task automatic req(string tag, logic [63:0] a);
    logic h, e;
    logic [63:0] r;
    model(a, h, e, r);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_addr_i = a;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk({tag, " valid"}, 64'(rsp_valid_o), 64'd1);
    chk({tag, " hit"},   64'(rsp_hit_o),   64'(h));
    chk({tag, " err"},   64'(rsp_err_o),   64'(e));
    chk({tag, " addr"},  rsp_addr_o,       r);
  endtask

  task automatic t_reset();
    logic [63:0] d;
    chk("R1 valid", 64'(rsp_valid_o), 0);
    chk("R1 hit",   64'(rsp_hit_o), 0);
    chk("R1 err",   64'(rsp_err_o), 0);
    chk("R1 addr",  rsp_addr_o, 0);
    for (int i = 0; i < 12; i++) begin
      rd(8'(8*i), d);
      chk("R1 reg zero", d, 0);
    end
  endtask

  task automatic t_regs();
    logic [63:0] d;
    for (int i = 0; i < 12; i++) wr(8'(8*i), {32'hA5A5_0000 + 32'(i), 32'h1234_5670 + 32'(i)});
    for (int i = 0; i < 12; i++) begin
      rd(8'(8*i), d);
      chk("R2 readback", d, {32'hA5A5_0000 + 32'(i), 32'h1234_5670 + 32'(i)});
    end
    // R3: unmapped writes ignored, reads zero
    wr(8'h60, '1); wr(8'h09, '1); wr(8'hF8, '1); wr(8'h03, '1);
    for (int i = 0; i < 12; i++) begin
      rd(8'(8*i), d);
      chk("R3 no side effect", d, {32'hA5A5_0000 + 32'(i), 32'h1234_5670 + 32'(i)});
    end
    rd(8'h60, d); chk("R3 read 0x60", d, 0);
    rd(8'h09, d); chk("R3 read 0x09", d, 0);
    rd(8'hF8, d); chk("R3 read 0xF8", d, 0);
    clear_all();
  endtask

  task automatic t_direct();
    clear_all();
    set_win(0, 64'h0010_0001, 64'h0, 64'h1_2340_0000);
    req("R8 direct 1MB", 64'h0010_5678);
    chk("R8 direct value", rsp_addr_o, 64'h1_2340_5678);
    // R4: bits above 30 ignored in compare and not passed through
    req("R4 upper ignored", 64'h3_8010_5678);
    chk("R4 upper value", rsp_addr_o, 64'h1_2340_5678);
    req("R9 miss", 64'h0020_0000);
  endtask

  task automatic t_mask();
    clear_all();
    set_win(1, 64'h4000_0001, 64'h0FF0_0000, 64'h8_0000_0000);
    req("R4 masked match", 64'h4ABC_DEF0);
    chk("R8 wide pass", rsp_addr_o, 64'h8_0ABC_DEF0);
    req("R9 outside window", 64'h5000_0000);
    chk("R9 miss addr", rsp_addr_o, 0);
  endtask

  task automatic t_disabled();
    clear_all();
    set_win(0, 64'h0010_0000, 64'h0, 64'h1_0000_0000);
    set_win(2, 64'h0010_0001, 64'h0, 64'h2_0000_0000);
    req("R5 skip disabled", 64'h0010_0ABC);
    chk("R5 from win2", rsp_addr_o, 64'h2_0000_0ABC);
    set_win(2, 64'h0010_0002, 64'h0, 64'h2_0000_0000);
    req("R5 disabled sg skipped", 64'h0010_0ABC);
  endtask

  task automatic t_priority();
    clear_all();
    set_win(0, 64'h0030_0001, 64'h0, 64'h1_0000_0000);
    set_win(3, 64'h0030_0001, 64'h0, 64'h3_0000_0000);
    req("R6 lowest wins", 64'h0031_1111);
    chk("R6 value", rsp_addr_o, 64'h1_0001_1111);
    set_win(2, 64'h0030_0003, 64'h0, 64'h2_0000_0000);
    req("R6 sg behind hit", 64'h0031_1111);
  endtask

  task automatic t_sg();
    clear_all();
    set_win(0, 64'h0010_0003, 64'h0, 64'h1_0000_0000);
    set_win(1, 64'h0010_0001, 64'h0, 64'h5_0000_0000);
    req("R7 sg error", 64'h0010_0044);
    chk("R7 err flag", 64'(rsp_err_o), 1);
    chk("R7 addr zero", rsp_addr_o, 0);
  endtask

  task automatic t_hold();
    clear_all();
    set_win(0, 64'h0010_0001, 64'h0, 64'h7_0000_0000);
    req("R10 hold setup", 64'h0010_0001);
    repeat (3) @(negedge clk_i);
    chk("R10 valid low", 64'(rsp_valid_o), 0);
    chk("R10 addr held", rsp_addr_o, 64'h7_0000_0001);
    chk("R10 hit held", 64'(rsp_hit_o), 1);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin sb[i] = '0; sm[i] = '0; st[i] = '0; end
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_regs();
    t_direct();
    t_mask();
    t_disabled();
    t_priority();
    t_sg();
    t_hold();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule